// File: doc/BRIEF.md
# Fixed-Priority Four-Master Bus Arbiter

This block decides which of four bus masters may drive a shared bus. Every master has a private request line and receives a private acknowledge line. The request lines go through a priority encoder, which turns them into a two-bit owner code and a valid flag. The code and the flag are stored in a register. A decoder then turns the stored code into a single acknowledge line. Master 0 has the highest priority and master 3 the lowest.

Handoff between masters is controlled by one shared bus-busy line. A master may use the bus only while its acknowledge is high. While it uses the bus it holds bus-busy high, and it drops bus-busy to let the bus go. The grant register loads a new value only on a clock edge where bus-busy is low. While bus-busy is high the current owner keeps its acknowledge, even if a master of higher priority starts to request.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is asserted and at the first edge after it, `ack` is 0000, `grant_valid` is 0 and `grant_code` is 0.
- R2: At an edge where bus-busy is low and at least one request is high, the arbiter selects the lowest-numbered requesting master. That master's index (0 to 3, in binary) appears on `grant_code`, and `grant_valid` is 1 after that edge.
- R3: At an edge where bus-busy is low and no request is high, `grant_valid` becomes 0, `grant_code` becomes 0 and `ack` becomes 0000.
- R4: `ack` has at most one bit set. When `grant_valid` is 1, bit `grant_code` of `ack` is the only bit set.
- R5: The grant outputs are registered. They change only at a clock edge and reflect the request lines sampled at that edge.
- R6: At an edge where bus-busy is high, `ack`, `grant_code` and `grant_valid` keep their values, whatever the request lines do.
- R7: At the first edge after bus-busy falls, the grant moves to the highest-priority master that is requesting at that edge.
- R8: A master that drops its request before an edge at which it would have been granted receives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Request lines; bit i belongs to master i |
| bus_busy | input | 1 | Shared busy line; the owner holds it high while it uses the bus |
| ack | output | 4 | One-hot acknowledge; bit i grants master i |
| grant_code | output | 2 | Encoded index of the current owner |
| grant_valid | output | 1 | High when an owner is granted |

## Verification
The hardest case to reach from the ports is a higher-priority request that arrives while a lower-priority master owns the bus. To create it, the bench first grants a low-priority master and raises bus-busy. It then asserts a higher-priority request, so the bench can check that the grant does not move during the busy window and moves only at the first edge after release. Withdrawal is covered the same way: a request is pulsed and removed while bus-busy is high, then bus-busy is released, and the bench checks that no acknowledge ever appears for that master. A reference model in the bench predicts `ack`, `grant_code` and `grant_valid` for every cycle and compares them with the outputs.

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int MASTERS = 4,
  localparam int CODE_W = $clog2(MASTERS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MASTERS-1:0] req,
  input  logic               bus_busy,
  output logic [MASTERS-1:0] ack,
  output logic [CODE_W-1:0]  grant_code,
  output logic               grant_valid
);

  logic [CODE_W-1:0] enc_code;
  logic              enc_valid;
  logic [CODE_W-1:0] code_q;
  logic              valid_q;

  assign enc_valid = |req;

  always_comb begin
    enc_code = '0;
    for (int i = MASTERS - 1; i >= 0; i--)
      if (req[i]) enc_code = CODE_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else if (!bus_busy) begin
      code_q  <= enc_valid ? enc_code : '0;
      valid_q <= enc_valid;
    end
  end

  for (genvar g = 0; g < MASTERS; g++) begin : g_dec
    assign ack[g] = valid_q && (code_q == CODE_W'(g));
  end

  assign grant_code  = code_q;
  assign grant_valid = valid_q;

endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int MASTERS = 4,
  localparam int CODE_W = $clog2(MASTERS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [MASTERS-1:0] req,
  input logic               bus_busy,
  input logic [MASTERS-1:0] ack,
  input logic [CODE_W-1:0]  grant_code,
  input logic               grant_valid
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (ack == '0 && !grant_valid && grant_code == '0));

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  a_r4_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (ack == (MASTERS'(1) << grant_code)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> ($stable(ack) && $stable(grant_code) && $stable(grant_valid)));

  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && req == '0) |=> (!grant_valid && ack == '0));

  a_r2_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && req[0]) |=> ack[0]);

endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.MASTERS(MASTERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy),
  .ack(ack), .grant_code(grant_code), .grant_valid(grant_valid)
);

// File: tb/prio_bus_arbiter_test.sv
module prio_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       bus_busy = 1'b0;
  logic [3:0] ack;
  logic [1:0] grant_code;
  logic       grant_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_code = 0;
  bit m_valid = 0;

  always #2 clk = ~clk;

  prio_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy),
    .ack(ack), .grant_code(grant_code), .grant_valid(grant_valid)
  );

  function automatic logic [3:0] m_ack();
    return m_valid ? 4'(1 << m_code) : 4'b0000;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (ack !== m_ack() || grant_code !== 2'(m_code) || grant_valid !== m_valid) begin
      errors++;
      $display("FAIL %s: ack=%b code=%0d valid=%b expected ack=%b code=%0d valid=%b",
               tag, ack, grant_code, grant_valid, m_ack(), m_code, m_valid);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic b, input string tag);
    @(negedge clk);
    req = r;
    bus_busy = b;
    @(posedge clk);
    if (!b) begin
      m_valid = (r != 0);
      m_code = 0;
      for (int i = 3; i >= 0; i--) if (r[i]) m_code = i;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    step(4'b0000, 1'b0, "R1 first edge");
    for (int p = 0; p < 16; p++) step(4'(p), 1'b0, "R2 R4 R5 pattern sweep");
    step(4'b0000, 1'b0, "R3 idle");
    step(4'b1000, 1'b0, "R2 lowest only");
    step(4'b1000, 1'b1, "R6 owner busy");
    step(4'b1001, 1'b1, "R6 higher arrives while busy");
    step(4'b0011, 1'b1, "R6 hold under change");
    step(4'b0110, 1'b0, "R7 release to master 1");
    step(4'b0100, 1'b1, "R6 master 1 busy");
    step(4'b0101, 1'b1, "R8 pulse master 0 while busy");
    step(4'b0100, 1'b1, "R8 master 0 withdrawn");
    step(4'b0100, 1'b0, "R8 release, master 2 wins");
    if (ack[0]) begin
      errors++;
      $display("FAIL R8: ack=%b expected bit0 clear", ack);
    end
    checks++;
    step(4'b0010, 1'b0, "R8 withdraw before busy");
    step(4'b0000, 1'b0, "R3 all withdrawn");
    step(4'b0000, 1'b1, "R6 idle busy");
    step(4'b1111, 1'b1, "R6 idle busy ignores req");
    step(4'b1111, 1'b0, "R7 release all");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule